// File: doc/BRIEF.md
# I/O Page Table Walker

This block turns an I/O virtual address into a physical page by walking a radix-512 page table in memory. A request gives the IOVA, the physical address of the root table and the level of that root table, from 1 to 6. At each step the walker reads one 64-bit entry through a single-outstanding request/response memory port. It checks the entry's present bit and decodes its next-level field. Then it either goes down to a lower table, stops at a leaf, or reports a fault.

A leaf returns the physical page base and the page size as a power-of-two exponent. A plain leaf takes the default size of the level it sits at. A leaf whose next-level field is 7 carries its own size as a run of one bits in its address field. Every walk ends with a one-cycle done pulse. The result stays on the outputs until the next walk ends.

Top module: `iopt_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken when `req_valid` and `req_ready` are both high, and only one walk runs at a time.
- R2: A start level of 0 or 7 ends the walk with a fault. No memory read is made, and `done` rises one cycle after the request is taken.
- R3: For a start level L below 6, an IOVA above 2^(12+9·L) − 1 faults without a memory read. At level 6 every IOVA is in range.
- R4: The first read address is the root pointer with bits 11:0 cleared, plus 8 times the 9-bit IOVA field at bit 12+9·(L−1). Every read address is 8-byte aligned.
- R5: Bit 0 of an entry is its present flag. An entry with bit 0 clear ends the walk with a fault, and `done` rises one cycle after the response.
- R6: The next-level field is entry bits 11:9. A value N from 1 up to one less than the current table level makes the walker read the table at level N. The read address is entry bits PA_W−1:12 shifted left by 12, plus 8 times the IOVA field at bit 12+9·(N−1).
- R7: A present entry whose next-level field is not 0, not 7 and not lower than the current table level ends the walk with a fault.
- R8: A present entry with next-level 0, read from a level-L table, is a leaf. Its exponent is 12+9·(L−1), and its base is entry bits PA_W−1:12 with every bit below the exponent cleared.
- R9: A present entry with next-level 7 is a large-page leaf. Force entry bits 11:0 to one and let n be the number of consecutive ones counted up from bit 0. The exponent is n+1, and the base is the entry address field with every bit below the exponent cleared.
- R10: At most one memory read is outstanding. `mem_req_valid` stays high with a stable address until `mem_req_ready` is seen.
- R11: `done` lasts one cycle. `fault`, `page_base` and `page_exp` change only when `done` is high and then hold. A fault gives base 0 and exponent 0.
- R12: During and right after reset, `req_ready` is 1 and `done`, `mem_req_valid`, `fault`, `page_base` and `page_exp` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_iova | input | VA_W | I/O virtual address to translate |
| req_root | input | PA_W | Physical address of the root table (bits 11:0 ignored) |
| req_level | input | 3 | Level of the root table, 1 to MAX_LVL |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | PA_W | 8-byte aligned entry address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Entry value |
| done | output | 1 | One-cycle pulse at the end of a walk |
| fault | output | 1 | Walk ended in a fault |
| page_base | output | PA_W | Physical base of the mapped page |
| page_exp | output | 7 | Log2 of the page size in bytes |

## Verification
The bench builds the walker with its defaults: a 64-bit IOVA, a 52-bit physical address and six table levels. These values let a 6-level root index through the top seven IOVA bits, where the range limit becomes all ones. They also let a large-page entry made of all ones give an exponent of 65, above the physical address width, so its base masks to zero. With the 43 upper IOVA bits, each level's range edge can be hit both just inside and just outside the limit. The memory model holds the request ready low in a repeating pattern, so every walk also crosses stalled read requests.

// File: rtl/iopt_pkg.sv
package iopt_pkg;

    localparam int PTE_W    = 64;
    localparam int PG_SHIFT = 12;
    localparam int IDX_W    = 9;
    localparam int LVL_W    = 3;
    localparam int EXP_W    = 7;
    localparam int PRES_BIT = 0;
    localparam int NL_LSB   = 9;

    localparam logic [LVL_W-1:0] NL_LEAF  = 3'd0;
    localparam logic [LVL_W-1:0] NL_LARGE = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } walk_st_e;

    // log2 of the default page size mapped by an entry of a table at tbl_lvl
    function automatic int leaf_exp(input logic [LVL_W-1:0] tbl_lvl);
        if (tbl_lvl == '0) return PG_SHIFT;
        return PG_SHIFT + IDX_W * (int'(tbl_lvl) - 1);
    endfunction

endpackage

// File: rtl/iopt_entry_addr.sv
module iopt_entry_addr
    import iopt_pkg::*;
#(
    parameter int VA_W = 64,
    parameter int PA_W = 52,
    localparam int VPN_W = VA_W - PG_SHIFT,
    localparam int FRM_W = PA_W - PG_SHIFT
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic [FRM_W-1:0] frame,
    input  logic [LVL_W-1:0] tbl_lvl,
    output logic [PA_W-1:0]  ent_addr
);

    logic [IDX_W-1:0] idx;
    int               base_pos;

    always_comb begin
        base_pos = (tbl_lvl == '0) ? 0 : IDX_W * (int'(tbl_lvl) - 1);
        for (int b = 0; b < IDX_W; b++) begin
            if (base_pos + b < VPN_W) idx[b] = vpn[base_pos + b];
            else                      idx[b] = 1'b0;
        end
        ent_addr = {frame, {PG_SHIFT{1'b0}}} + PA_W'({idx, 3'b000});
    end

endmodule

// File: rtl/iopt_range_chk.sv
module iopt_range_chk
    import iopt_pkg::*;
#(
    parameter int VA_W    = 64,
    parameter int MAX_LVL = 6,
    localparam int HI_W   = VA_W - PG_SHIFT - IDX_W,
    localparam int NLVL   = 1 << LVL_W
) (
    input  logic [HI_W-1:0]  va_hi,
    input  logic [LVL_W-1:0] start_lvl,
    output logic             start_ok
);

    logic [NLVL-1:0] ok_vec;

    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        if (l == 0 || l > MAX_LVL) begin : g_bad
            assign ok_vec[l] = 1'b0;
        end else if (l == MAX_LVL || IDX_W * (l - 1) >= HI_W) begin : g_all
            assign ok_vec[l] = 1'b1;
        end else begin : g_lim
            assign ok_vec[l] = ~|va_hi[HI_W-1:IDX_W*(l-1)];
        end
    end

    assign start_ok = ok_vec[start_lvl];

endmodule

// File: rtl/iopt_leaf_dec.sv
module iopt_leaf_dec
    import iopt_pkg::*;
#(
    parameter int PA_W = 52,
    localparam int HI_W = PTE_W - PG_SHIFT
) (
    input  logic [HI_W-1:0]  pte_hi,
    input  logic             is_large,
    input  logic [LVL_W-1:0] tbl_lvl,
    output logic [EXP_W-1:0] exp_o,
    output logic [PA_W-1:0]  base_o
);

    always_comb begin
        int   run_len;
        logic in_run;
        int   e;
        run_len = 0;
        in_run  = 1'b1;
        for (int i = 0; i < HI_W; i++) begin
            if (in_run && pte_hi[i]) run_len = run_len + 1;
            else                     in_run  = 1'b0;
        end
        if (is_large) e = PG_SHIFT + run_len + 1;
        else          e = leaf_exp(tbl_lvl);
        exp_o  = EXP_W'(e);
        base_o = '0;
        for (int i = PG_SHIFT; i < PA_W; i++) begin
            if (i >= e) base_o[i] = pte_hi[i-PG_SHIFT];
        end
    end

endmodule

// File: rtl/iopt_walker.sv
module iopt_walker
    import iopt_pkg::*;
#(
    parameter int VA_W    = 64,
    parameter int PA_W    = 52,
    parameter int MAX_LVL = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_iova,
    input  logic [PA_W-1:0]  req_root,
    input  logic [2:0]       req_level,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [63:0]      mem_rsp_data,
    output logic             done,
    output logic             fault,
    output logic [PA_W-1:0]  page_base,
    output logic [6:0]       page_exp
);

    localparam int VPN_W = VA_W - PG_SHIFT;
    localparam int FRM_W = PA_W - PG_SHIFT;
    localparam int HI_W  = VPN_W - IDX_W;

    typedef struct packed {
        walk_st_e         st;
        logic [LVL_W-1:0] lvl;
        logic [VPN_W-1:0] vpn;
        logic [PA_W-1:0]  addr;
        logic             done;
        logic             fault;
        logic [PA_W-1:0]  base;
        logic [EXP_W-1:0] exp;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    logic [PA_W-1:0]  root_addr_w;
    logic [PA_W-1:0]  next_addr_w;
    logic             start_ok_w;
    logic [EXP_W-1:0] leaf_exp_w;
    logic [PA_W-1:0]  leaf_base_w;
    logic             ent_present;
    logic [LVL_W-1:0] ent_nl;
    logic             unused_in_bits;

    assign ent_present    = mem_rsp_data[PRES_BIT];
    assign ent_nl         = mem_rsp_data[NL_LSB +: LVL_W];
    assign unused_in_bits = ^{req_iova[PG_SHIFT-1:0], req_root[PG_SHIFT-1:0],
                              mem_rsp_data[NL_LSB-1:PRES_BIT+1]};

    iopt_entry_addr #(.VA_W(VA_W), .PA_W(PA_W)) u_root_addr (
        .vpn     (req_iova[VA_W-1:PG_SHIFT]),
        .frame   (req_root[PA_W-1:PG_SHIFT]),
        .tbl_lvl (req_level),
        .ent_addr(root_addr_w)
    );

    iopt_entry_addr #(.VA_W(VA_W), .PA_W(PA_W)) u_next_addr (
        .vpn     (r_q.vpn),
        .frame   (mem_rsp_data[PA_W-1:PG_SHIFT]),
        .tbl_lvl (ent_nl),
        .ent_addr(next_addr_w)
    );

    iopt_range_chk #(.VA_W(VA_W), .MAX_LVL(MAX_LVL)) u_range (
        .va_hi    (req_iova[VA_W-1:PG_SHIFT+IDX_W]),
        .start_lvl(req_level),
        .start_ok (start_ok_w)
    );

    iopt_leaf_dec #(.PA_W(PA_W)) u_leaf (
        .pte_hi  (mem_rsp_data[PTE_W-1:PG_SHIFT]),
        .is_large(ent_nl == NL_LARGE),
        .tbl_lvl (r_q.lvl),
        .exp_o   (leaf_exp_w),
        .base_o  (leaf_base_w)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!start_ok_w) begin
                        r_d.done  = 1'b1;
                        r_d.fault = 1'b1;
                        r_d.base  = '0;
                        r_d.exp   = '0;
                    end else begin
                        r_d.st   = ST_ISSUE;
                        r_d.lvl  = req_level;
                        r_d.vpn  = req_iova[VA_W-1:PG_SHIFT];
                        r_d.addr = root_addr_w;
                    end
                end
            end
            ST_ISSUE: begin
                if (mem_req_ready) r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (ent_present && (ent_nl == NL_LEAF || ent_nl == NL_LARGE)) begin
                        r_d.st    = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.fault = 1'b0;
                        r_d.base  = leaf_base_w;
                        r_d.exp   = leaf_exp_w;
                    end else if (ent_present && ent_nl < r_q.lvl) begin
                        r_d.st   = ST_ISSUE;
                        r_d.lvl  = ent_nl;
                        r_d.addr = next_addr_w;
                    end else begin
                        r_d.st    = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.fault = 1'b1;
                        r_d.base  = '0;
                        r_d.exp   = '0;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req_ready     = (r_q.st == ST_IDLE);
    assign mem_req_valid = (r_q.st == ST_ISSUE);
    assign mem_req_addr  = r_q.addr;
    assign done          = r_q.done;
    assign fault         = r_q.fault;
    assign page_base     = r_q.base;
    assign page_exp      = r_q.exp;

endmodule

// File: rtl/iopt_walker_chk.sv
module iopt_walker_chk #(
    parameter int PA_W = 52
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            mem_rsp_valid,
    input logic            rsp_present,
    input logic            done,
    input logic            fault,
    input logic [PA_W-1:0] page_base,
    input logic [6:0]      page_exp
);

    logic outstanding;

    always_ff @(posedge clk) begin
        if (!rst_n)                             outstanding <= 1'b0;
        else if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
        else if (mem_rsp_valid)                  outstanding <= 1'b0;
    end

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !req_ready); // R1
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !mem_req_valid); // R10
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R10
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[2:0] == 3'b000); // R4
    AST_ABSENT_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding && mem_rsp_valid && !rsp_present |=> done && fault); // R5
    AST_LEAF_EXP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fault |-> page_exp >= 7'd12); // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done && !(req_valid && req_ready) |=> !done); // R11
    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |-> page_base == '0 && page_exp == 7'd0); // R11
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(page_base) || !$stable(page_exp) || !$stable(fault) |-> done); // R11

endmodule

bind iopt_walker iopt_walker_chk #(.PA_W(PA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .rsp_present  (mem_rsp_data[0]),
    .done         (done),
    .fault        (fault),
    .page_base    (page_base),
    .page_exp     (page_exp)
);

// File: tb/iopt_walker_tb.sv
module iopt_walker_tb;

    localparam int VA_W = 64;
    localparam int PA_W = 52;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [VA_W-1:0] req_iova = '0;
    logic [PA_W-1:0] req_root = '0;
    logic [2:0]      req_level = '0;
    logic            mem_req_valid;
    logic            mem_req_ready;
    logic [PA_W-1:0] mem_req_addr;
    logic            mem_rsp_valid;
    logic [63:0]     mem_rsp_data;
    logic            done;
    logic            fault;
    logic [PA_W-1:0] page_base;
    logic [6:0]      page_exp;

    always #10 clk = ~clk;

    iopt_walker #(.VA_W(VA_W), .PA_W(PA_W), .MAX_LVL(6)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_iova(req_iova), .req_root(req_root), .req_level(req_level),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .fault(fault), .page_base(page_base), .page_exp(page_exp)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // memory model
    logic [63:0] mem_img [logic [PA_W-1:0]];
    logic [PA_W-1:0] rd_log [16];
    int rd_cnt = 0;
    bit pending = 0;
    logic [PA_W-1:0] pend_addr = '0;
    int stall_ctr = 0;

    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pending) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_img.exists(pend_addr) ? mem_img[pend_addr] : 64'd0;
                pending = 0;
            end
            stall_ctr++;
            mem_req_ready = (stall_ctr % 3) != 0;
            if (rst_n && mem_req_valid && mem_req_ready) begin
                pending   = 1;
                pend_addr = mem_req_addr;
                if (rd_cnt < 16) rd_log[rd_cnt] = mem_req_addr;
                rd_cnt++;
            end
        end
    end

    typedef struct packed {
        logic [63:0]     iova;
        logic [PA_W-1:0] root;
        logic [2:0]      lvl;
        logic            flt;
        logic [6:0]      pexp;
        logic [PA_W-1:0] base;
        logic [3:0]      nrd;
        logic [3:0]      rq;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_0080_8060_5123, 52'h10000, 3'd4, 1'b0, 7'd12, 52'hABCDE000,     4'd4, 4'd6}, // R6 R8 4-level 4K
        '{64'h0000_0080_8080_0007, 52'h10000, 3'd4, 1'b0, 7'd21, 52'h12_3440_0000, 4'd3, 4'd8}, // R8 2M leaf
        '{64'h0000_0081_8000_0000, 52'h10000, 3'd4, 1'b0, 7'd17, 52'h5_0000_0000,  4'd2, 4'd9}, // R9 large
        '{64'h0000_0081_C000_0000, 52'h10000, 3'd4, 1'b1, 7'd0,  52'h0,            4'd2, 4'd5}, // R5 absent
        '{64'h0000_0080_80A0_0000, 52'h10000, 3'd4, 1'b1, 7'd0,  52'h0,            4'd3, 4'd7}, // R7 bad nl
        '{64'h0000_0100_0000_9000, 52'h10000, 3'd4, 1'b0, 7'd12, 52'hDEADB000,     4'd2, 4'd6}, // R6 skip
        '{64'h0001_0000_0000_0000, 52'h10000, 3'd4, 1'b1, 7'd0,  52'h0,            4'd0, 4'd3}, // R3 above
        '{64'h0000_FFFF_FFFF_F000, 52'h10000, 3'd4, 1'b1, 7'd0,  52'h0,            4'd1, 4'd3}, // R3 edge
        '{64'h0000_0000_0000_5000, 52'h40000, 3'd0, 1'b1, 7'd0,  52'h0,            4'd0, 4'd2}, // R2 lvl0
        '{64'h0000_0000_0000_5000, 52'h40000, 3'd7, 1'b1, 7'd0,  52'h0,            4'd0, 4'd2}, // R2 lvl7
        '{64'hFFFF_FFFF_FFFF_FFFF, 52'h90000, 3'd6, 1'b1, 7'd0,  52'h0,            4'd1, 4'd3}, // R3 lvl6
        '{64'h0000_0000_0000_5000, 52'h40000, 3'd1, 1'b0, 7'd12, 52'hABCDE000,     4'd1, 4'd8}, // R8 lvl1
        '{64'h0000_0000_0020_0000, 52'h40000, 3'd1, 1'b1, 7'd0,  52'h0,            4'd0, 4'd3}, // R3 lvl1
        '{64'h0000_0180_0000_0000, 52'h10000, 3'd4, 1'b0, 7'd39, 52'h80_0000_0000, 4'd1, 4'd8}, // R8 root leaf
        '{64'h0000_0200_0000_0000, 52'h10000, 3'd4, 1'b0, 7'd65, 52'h0,            4'd1, 4'd9}  // R9 all ones
    };

    task automatic run_walk(input vec_t v, input int vi, output bit got);
        got = 0;
        rd_cnt = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_iova  = v.iova;
        req_root  = v.root;
        req_level = v.lvl;
        @(negedge clk);
        req_valid = 1'b0;
        if (v.nrd != 0)
            chk(req_ready == 1'b0, $sformatf("R1 vec %0d ready while busy", vi),
                64'(req_ready), 64'd0);
        for (int c = 0; c < 200; c++) begin
            if (done) begin
                got = 1;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        mem_img[52'h10008] = 64'h20601;
        mem_img[52'h10010] = 64'h50201;
        mem_img[52'h10018] = 64'h80_0000_0001;
        mem_img[52'h10020] = 64'hFFFF_FFFF_FFFF_FFFF;
        mem_img[52'h20010] = 64'h30401;
        mem_img[52'h20030] = 64'h5_0000_FE01;
        mem_img[52'h20038] = 64'h60400;
        mem_img[52'h30018] = 64'h40201;
        mem_img[52'h30020] = 64'h12_3440_1001;
        mem_img[52'h30028] = 64'h70401;
        mem_img[52'h40028] = 64'hABCDE001;
        mem_img[52'h50048] = 64'hDEADB001;

        repeat (3) @(negedge clk);
        // R12 reset state
        chk(req_ready == 1'b1, "R12 ready in reset", 64'(req_ready), 64'd1);
        chk(done == 1'b0 && mem_req_valid == 1'b0, "R12 done/mem_req in reset",
            64'({done, mem_req_valid}), 64'd0);
        chk(fault == 1'b0 && page_base == '0 && page_exp == '0, "R12 result in reset",
            64'(page_base), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && done == 1'b0, "R12 after reset",
            64'({req_ready, done}), 64'b10);

        for (int vi = 0; vi < NV; vi++) begin
            bit got;
            run_walk(VECS[vi], vi, got);
            chk(got, $sformatf("R11 vec %0d done seen", vi), 64'(got), 64'd1);
            if (got) begin
                logic        f0;
                logic [51:0] b0;
                logic [6:0]  e0;
                chk(fault == VECS[vi].flt, $sformatf("R%0d vec %0d fault", VECS[vi].rq, vi),
                    64'(fault), 64'(VECS[vi].flt));
                chk(page_exp == VECS[vi].pexp, $sformatf("R%0d vec %0d exp", VECS[vi].rq, vi),
                    64'(page_exp), 64'(VECS[vi].pexp));
                chk(page_base == VECS[vi].base, $sformatf("R%0d vec %0d base", VECS[vi].rq, vi),
                    64'(page_base), 64'(VECS[vi].base));
                chk(rd_cnt == int'(VECS[vi].nrd), $sformatf("R%0d vec %0d reads", VECS[vi].rq, vi),
                    64'(rd_cnt), 64'(VECS[vi].nrd));
                f0 = fault; b0 = page_base; e0 = page_exp;
                @(negedge clk);
                chk(done == 1'b0, $sformatf("R11 vec %0d done one cycle", vi), 64'(done), 64'd0);
                repeat (2) @(negedge clk);
                chk(fault == f0 && page_base == b0 && page_exp == e0,
                    $sformatf("R11 vec %0d result holds", vi), 64'(page_base), 64'(b0));
                if (vi == 0) begin
                    // R4 root address, R6 descent addresses
                    chk(rd_log[0] == 52'h10008, "R4 first read address", 64'(rd_log[0]), 64'h10008);
                    chk(rd_log[1] == 52'h20010, "R6 level3 read address", 64'(rd_log[1]), 64'h20010);
                    chk(rd_log[2] == 52'h30018, "R6 level2 read address", 64'(rd_log[2]), 64'h30018);
                    chk(rd_log[3] == 52'h40028, "R6 level1 read address", 64'(rd_log[3]), 64'h40028);
                end
                if (vi == 5)
                    chk(rd_log[1] == 52'h50048, "R6 skipped-level read address",
                        64'(rd_log[1]), 64'h50048);
                if (vi == 10)
                    chk(rd_log[0] == 52'h903F8, "R4 level6 root read address",
                        64'(rd_log[0]), 64'h903F8);
                if (vi == 1)
                    chk(rd_cnt <= 3, "R10 no duplicate reads", 64'(rd_cnt), 64'd3);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule